// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Staged Register Updates

This block is a memory-mapped pulse-width modulator with two independent output channels. Each channel scales the system clock down by a programmable prescaler. It then counts through a programmable period and drives its output active while the period count is below a programmable duty value. The output polarity can be inverted.

Software writes go into staging copies of the registers. For each staged register, a pending flag stays set until the hardware has moved the value into the active copy that drives the counters. A shared status word shows every pending flag, and software polls it before the next write to the same register.

While a channel is running, prescaler, period and duty values move to the active copies only at a period boundary when autoload is selected. The prescaler and period can also be loaded on demand by setting one-shot load bits in the control register. A stopped channel takes every staged value one clock after the write. A channel can be disabled gracefully, finishing its current period, or stopped at once.

Top module: `pwm_dual_sync`

## Requirements
- R1: Channel c (c = 0, 1) owns the 16-byte window at byte address c·0x10. Offsets are: control +0x0, prescaler +0x4, period +0x8, duty +0xC. Reads return the staged values. The prescaler is 10 bits wide and the period and duty are 12 bits wide; unused upper bits read 0. Control reads return bits [3:0] only. After reset every register reads 0.
- R2: The status word at 0x40 holds four pending bits per channel, starting at bit 8·c. Their order is control (+0), prescaler (+1), period (+2), duty (+3). Writes to 0x40 change nothing.
- R3: A control write sets the control pending bit for exactly one cycle after the write edge, unless another control write follows. The staged control value becomes active on the edge that clears that bit. Control bit 0 is enable, bit 1 invert, bit 2 autoload and bit 3 stop-immediately.
- R4: While a channel is stopped, a prescaler, period or duty write becomes active on the edge after the write edge, and its pending bit clears on that same edge.
- R5: While a channel runs with autoload active, staged prescaler, period and duty values become active on the period-end edge. Their pending bits clear on that edge.
- R6: While a channel runs without autoload, staged values stay pending and the active ones are unchanged. A control write with bit 4 set loads the staged prescaler, and one with bit 5 set loads the staged period. The load takes effect on the same edge that makes that control value active. Bits 4 and 5 are not stored.
- R7: With active prescaler P, period N and duty D, a period lasts (P+1)·(N+1) clocks. The output is active for the first D·(P+1) clocks of the period. D = 0 keeps it inactive, and D > N keeps it active throughout. A period ends when the prescale count has reached P and the period count has reached N or more.
- R8: The active level is 1, or 0 when invert is active. A stopped channel drives the inactive level.
- R9: A stopped channel starts counting on the edge after enable becomes active. When enable is cleared with stop-immediately clear, the channel runs to the end of its period and stops there. When enable is cleared with stop-immediately set, the channel stops on the next edge.
- R10: The unimplemented channel windows 0x20 to 0x3F and the addresses 0x44 to 0x7F read 0. Writes to them have no effect.
- R11: The two channels run independently; writes to one channel do not change the other's output or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the counters |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | 7 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: two channels, a 10-bit prescaler and a 12-bit period. Small programmed prescaler and period values keep each PWM period to a few dozen clocks. That puts many period boundaries within a short run, so autoload transfers, graceful and immediate stops, and one-shot loads landing mid-period can all be compared cycle by cycle against the behavioural model. Duty values of zero and above the period, and writes to the reserved windows, are covered with the same parameters.

// File: rtl/pwm_pkg.sv
// Shared types for the dual PWM: active control fields and register slot codes.
package pwm_pkg;
    // Active control bits, packed so bit 0 is enable.
    typedef struct packed {
        logic stop_now;
        logic autold;
        logic inv;
        logic en;
    } ctl_t;

    // Register slot inside a channel window (byte offset / 4).
    typedef enum logic [1:0] {
        SLOT_CTL  = 2'd0,
        SLOT_PRE  = 2'd1,
        SLOT_PER  = 2'd2,
        SLOT_DUTY = 2'd3
    } slot_e;
endpackage

// File: rtl/pwm_chan_regs.sv
// Staged and active register copies for one PWM channel.
// Assumes: wr_en is already qualified with this channel's window; running and
// period_end come from this channel's counter in the same cycle.
module pwm_chan_regs
    import pwm_pkg::*;
#(
    parameter int PRE_W  = 10,
    parameter int PER_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  slot_e             wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              running,
    input  logic              period_end,
    output ctl_t              act_ctl,
    output logic [PRE_W-1:0]  act_pre,
    output logic [PER_W-1:0]  act_per,
    output logic [PER_W-1:0]  act_duty,
    output logic [3:0]        sh_ctl,
    output logic [PRE_W-1:0]  sh_pre,
    output logic [PER_W-1:0]  sh_per,
    output logic [PER_W-1:0]  sh_duty,
    output logic [3:0]        pend
);
    logic ld_pre_q, ld_per_q;
    logic wr_ctl, wr_pre, wr_per, wr_duty;
    logic tr_pre, tr_per, tr_duty;

    assign wr_ctl  = wr_en && (wr_slot == SLOT_CTL);
    assign wr_pre  = wr_en && (wr_slot == SLOT_PRE);
    assign wr_per  = wr_en && (wr_slot == SLOT_PER);
    assign wr_duty = wr_en && (wr_slot == SLOT_DUTY);

    // Transfer conditions: idle channel, autoload at period end, or one-shot load.
    assign tr_duty = !running || (act_ctl.autold && period_end);
    assign tr_pre  = tr_duty || ld_pre_q;
    assign tr_per  = tr_duty || ld_per_q;

    // Control staging, one-cycle apply and one-shot load requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ctl   <= '0;
            act_ctl  <= '0;
            ld_pre_q <= 1'b0;
            ld_per_q <= 1'b0;
            pend[0]  <= 1'b0;
        end else begin
            act_ctl  <= ctl_t'(sh_ctl);
            pend[0]  <= wr_ctl;
            ld_pre_q <= wr_ctl && wr_data[4];
            ld_per_q <= wr_ctl && wr_data[5];
            if (wr_ctl) sh_ctl <= wr_data[3:0];
        end
    end

    // Prescaler staging and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            act_pre <= '0;
            pend[1] <= 1'b0;
        end else begin
            if (tr_pre) act_pre <= sh_pre;
            if (wr_pre) begin
                sh_pre  <= wr_data[PRE_W-1:0];
                pend[1] <= 1'b1;
            end else if (tr_pre) begin
                pend[1] <= 1'b0;
            end
        end
    end

    // Period staging and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per  <= '0;
            act_per <= '0;
            pend[2] <= 1'b0;
        end else begin
            if (tr_per) act_per <= sh_per;
            if (wr_per) begin
                sh_per  <= wr_data[PER_W-1:0];
                pend[2] <= 1'b1;
            end else if (tr_per) begin
                pend[2] <= 1'b0;
            end
        end
    end

    // Duty staging and transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_duty  <= '0;
            act_duty <= '0;
            pend[3]  <= 1'b0;
        end else begin
            if (tr_duty) act_duty <= sh_duty;
            if (wr_duty) begin
                sh_duty <= wr_data[PER_W-1:0];
                pend[3] <= 1'b1;
            end else if (tr_duty) begin
                pend[3] <= 1'b0;
            end
        end
    end

    AST_CTL_PEND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] && !wr_ctl |=> !pend[0]); // R3
    AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !wr_duty |=> !pend[3]); // R4
    AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        running && act_ctl.autold && period_end |=> act_duty == $past(sh_duty)); // R5
    AST_HOLD_NOAUTO: assert property (@(posedge clk) disable iff (!rst_n)
        running && !act_ctl.autold && !ld_pre_q |=> $stable(act_pre)); // R6
endmodule

// File: rtl/pwm_chan_gen.sv
// Counter and output stage for one PWM channel.
// Assumes: the active values only change at edges decided by pwm_chan_regs.
module pwm_chan_gen
    import pwm_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             act_ctl,
    input  logic [PRE_W-1:0] act_pre,
    input  logic [PER_W-1:0] act_per,
    input  logic [PER_W-1:0] act_duty,
    output logic             running,
    output logic             period_end,
    output logic             pwm_out
);
    logic [PRE_W-1:0] pc;
    logic [PER_W-1:0] cnt;
    logic             tick;

    assign tick       = (pc >= act_pre);
    assign period_end = running && tick && (cnt >= act_per);
    assign pwm_out    = (running && (cnt < act_duty)) ^ act_ctl.inv;

    // Start, stop and count sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pc      <= '0;
            cnt     <= '0;
        end else if (!running) begin
            pc      <= '0;
            cnt     <= '0;
            running <= act_ctl.en;
        end else if (!act_ctl.en && act_ctl.stop_now) begin
            pc      <= '0;
            cnt     <= '0;
            running <= 1'b0;
        end else if (period_end) begin
            pc      <= '0;
            cnt     <= '0;
            running <= act_ctl.en;
        end else if (tick) begin
            pc      <= '0;
            cnt     <= cnt + 1'b1;
        end else begin
            pc      <= pc + 1'b1;
        end
    end

    AST_STOP_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        running && !act_ctl.en && act_ctl.stop_now |=> !running); // R9
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> pwm_out == act_ctl.inv); // R8
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> cnt == '0); // R7
    AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        running && act_duty == '0 |-> pwm_out == act_ctl.inv); // R7
endmodule

// File: rtl/pwm_dual_sync.sv
// Dual PWM top: address decode, read mux and the per-channel instances.
// Assumes: single clock; word-aligned register port with combinational reads.
module pwm_dual_sync
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int PRE_W  = 10,
    parameter int PER_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int DATA_W  = 32;
    localparam int STAT_SH = 8;
    localparam logic [4:0] STAT_WORD = 5'h10;

    logic             in_win;
    logic [1:0]       win_idx;
    slot_e            slot;
    logic [3:0]       sh_ctl   [NUM_CH];
    logic [PRE_W-1:0] sh_pre   [NUM_CH];
    logic [PER_W-1:0] sh_per   [NUM_CH];
    logic [PER_W-1:0] sh_duty  [NUM_CH];
    logic [3:0]       pend     [NUM_CH];

    assign in_win  = !bus_addr[6];
    assign win_idx = bus_addr[5:4];
    assign slot    = slot_e'(bus_addr[3:2]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctl_t             act_ctl;
        logic [PRE_W-1:0] act_pre;
        logic [PER_W-1:0] act_per, act_duty;
        logic             running, period_end, sel;

        assign sel = bus_wr && in_win && (win_idx == 2'(c));

        pwm_chan_regs #(.PRE_W(PRE_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(sel), .wr_slot(slot), .wr_data(bus_wdata),
            .running(running), .period_end(period_end), .act_ctl(act_ctl),
            .act_pre(act_pre), .act_per(act_per), .act_duty(act_duty),
            .sh_ctl(sh_ctl[c]), .sh_pre(sh_pre[c]), .sh_per(sh_per[c]),
            .sh_duty(sh_duty[c]), .pend(pend[c])
        );

        pwm_chan_gen #(.PRE_W(PRE_W), .PER_W(PER_W)) u_gen (
            .clk(clk), .rst_n(rst_n), .act_ctl(act_ctl), .act_pre(act_pre),
            .act_per(act_per), .act_duty(act_duty), .running(running),
            .period_end(period_end), .pwm_out(pwm_out[c])
        );
    end

    // Read mux: channel windows, status word, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[6:2] == STAT_WORD) begin
            for (int c = 0; c < NUM_CH; c++) begin
                bus_rdata[c*STAT_SH +: 4] = pend[c];
            end
        end else if (in_win) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (win_idx == 2'(c)) begin
                    case (slot)
                        SLOT_CTL:  bus_rdata[3:0]       = sh_ctl[c];
                        SLOT_PRE:  bus_rdata[PRE_W-1:0] = sh_pre[c];
                        SLOT_PER:  bus_rdata[PER_W-1:0] = sh_per[c];
                        default:   bus_rdata[PER_W-1:0] = sh_duty[c];
                    endcase
                end
            end
        end
    end
endmodule

// File: tb/pwm_dual_sync_bench.sv
`timescale 1ns/100ps
// Behavioural reference model compared against the design on every clock.
module pwm_dual_sync_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    pwm_dual_sync u_pwm_dual_sync (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // Reference state per channel
    int shc[2], acc[2], shp[2], shn[2], shd[2], acp[2], acn[2], acd[2];
    int pnd[2][4], ldp[2], ldn[2], run[2], pcnt[2], cnt[2];

    function automatic int m_read(input int a);
        int w;
        w = a & 32'h7C;
        if (w == 32'h40) return pnd[0][0] | (pnd[0][1] << 1) | (pnd[0][2] << 2) | (pnd[0][3] << 3)
                              | (pnd[1][0] << 8) | (pnd[1][1] << 9) | (pnd[1][2] << 10) | (pnd[1][3] << 11);
        if (w < 32'h20) begin
            case ((w >> 2) & 3)
                0: return shc[w >> 4];
                1: return shp[w >> 4];
                2: return shn[w >> 4];
                default: return shd[w >> 4];
            endcase
        end
        return 0;
    endfunction

    // Model step at each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        cycles++;
        for (int c = 0; c < 2; c++) begin
            int en, st, au, pe, trp, trn, trd, wsel, rg, wd;
            if (!rst_n) begin
                shc[c] = 0; acc[c] = 0; shp[c] = 0; shn[c] = 0; shd[c] = 0;
                acp[c] = 0; acn[c] = 0; acd[c] = 0; ldp[c] = 0; ldn[c] = 0;
                run[c] = 0; pcnt[c] = 0; cnt[c] = 0;
                for (int k = 0; k < 4; k++) pnd[c][k] = 0;
            end else begin
                en = acc[c] & 1; au = (acc[c] >> 2) & 1; st = (acc[c] >> 3) & 1;
                pe = (run[c] != 0 && pcnt[c] >= acp[c] && cnt[c] >= acn[c]) ? 1 : 0;
                trd = (run[c] == 0 || (au != 0 && pe != 0)) ? 1 : 0;
                trp = (trd != 0 || ldp[c] != 0) ? 1 : 0;
                trn = (trd != 0 || ldn[c] != 0) ? 1 : 0;
                wsel = (bus_wr && bus_addr < 7'h20 && int'(bus_addr[4]) == c) ? 1 : 0;
                rg = int'(bus_addr[3:2]);
                wd = int'(bus_wdata);
                // counter
                if (run[c] == 0) begin pcnt[c] = 0; cnt[c] = 0; run[c] = en; end
                else if (en == 0 && st != 0) begin pcnt[c] = 0; cnt[c] = 0; run[c] = 0; end
                else if (pe != 0) begin pcnt[c] = 0; cnt[c] = 0; run[c] = en; end
                else if (pcnt[c] >= acp[c]) begin pcnt[c] = 0; cnt[c]++; end
                else pcnt[c]++;
                // registers
                acc[c] = shc[c];
                if (trp != 0) acp[c] = shp[c];
                if (trn != 0) acn[c] = shn[c];
                if (trd != 0) acd[c] = shd[c];
                if (wsel != 0 && rg == 0) begin
                    shc[c] = wd & 15; pnd[c][0] = 1; ldp[c] = (wd >> 4) & 1; ldn[c] = (wd >> 5) & 1;
                end else begin
                    pnd[c][0] = 0; ldp[c] = 0; ldn[c] = 0;
                end
                if (wsel != 0 && rg == 1) begin shp[c] = wd & 1023; pnd[c][1] = 1; end
                else if (trp != 0) pnd[c][1] = 0;
                if (wsel != 0 && rg == 2) begin shn[c] = wd & 4095; pnd[c][2] = 1; end
                else if (trn != 0) pnd[c][2] = 0;
                if (wsel != 0 && rg == 3) begin shd[c] = wd & 4095; pnd[c][3] = 1; end
                else if (trd != 0) pnd[c][3] = 0;
            end
        end
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Compare outputs away from the edge, after the drivers have settled.
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            logic [1:0]  exp_out;
            logic [31:0] exp_rd;
            for (int c = 0; c < 2; c++)
                exp_out[c] = ((run[c] != 0 && cnt[c] < acd[c]) ? 1'b1 : 1'b0) ^ 1'((acc[c] >> 1) & 1);
            exp_rd = 32'(m_read(int'(bus_addr)));
            vectors++;
            if (pwm_out !== exp_out) begin
                miscompares++;
                $display("FAIL %s pwm_out t=%0t actual %b expected %b", tag, $time, pwm_out, exp_out);
            end
            if (bus_rdata !== exp_rd) begin
                miscompares++;
                $display("FAIL %s rdata addr %h actual %h expected %h", tag, bus_addr, bus_rdata, exp_rd);
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 7'h40;
    endtask

    task automatic idle(input int n, input logic [6:0] a);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 R10: reset values of every address
        tag = "R1";
        for (int a = 0; a < 128; a += 4) idle(1, 7'(a));
        // R1 R4: field widths and idle transfer
        tag = "R4";
        wr(7'h04, 32'hFFFF_FFFF); idle(2, 7'h04);
        wr(7'h04, 32'd3); wr(7'h08, 32'hFFFF_F009); wr(7'h0C, 32'd4);
        idle(3, 7'h40); idle(1, 7'h08); idle(1, 7'h0C);
        // R7: basic waveform, period 4*10 clocks, active 16
        tag = "R7";
        wr(7'h00, 32'h1); idle(130, 7'h40);
        // R8: inverted output
        tag = "R8";
        wr(7'h00, 32'h3); idle(60, 7'h40);
        // R5: autoload at period end
        tag = "R5";
        wr(7'h00, 32'h5); wr(7'h0C, 32'd7); wr(7'h08, 32'd5); idle(100, 7'h40);
        // R6: no autoload keeps values pending, then one-shot loads
        tag = "R6";
        wr(7'h00, 32'h1); wr(7'h04, 32'd1); wr(7'h08, 32'd3); wr(7'h0C, 32'd2);
        idle(40, 7'h40); wr(7'h00, 32'h31); idle(60, 7'h40);
        // R11: second channel, duty zero then duty above period
        tag = "R11";
        wr(7'h14, 32'd0); wr(7'h18, 32'd6); wr(7'h1C, 32'd0); wr(7'h10, 32'h5);
        idle(30, 7'h40); wr(7'h1C, 32'hFFF); idle(40, 7'h1C); idle(10, 7'h40);
        // R9: graceful stop, restart, immediate stop
        tag = "R9";
        wr(7'h00, 32'h0); idle(60, 7'h40);
        wr(7'h00, 32'h1); idle(20, 7'h40);
        wr(7'h00, 32'h8); idle(10, 7'h40);
        wr(7'h00, 32'h9); idle(20, 7'h40);
        // R2: status is read-only
        tag = "R2";
        wr(7'h40, 32'hFFFF_FFFF); idle(3, 7'h40);
        // R3: control pending bit on channel 1, back-to-back writes
        tag = "R3";
        wr(7'h10, 32'h1); wr(7'h10, 32'h5); idle(3, 7'h40);
        // R10: reserved windows ignore writes and read zero
        tag = "R10";
        for (int a = 32'h20; a < 128; a += 4) if (a != 32'h40) wr(7'(a), 32'hA5A5_A5A5);
        for (int a = 32'h20; a < 128; a += 4) idle(1, 7'(a));
        idle(40, 7'h10);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule